// File: doc/BRIEF.md
# Frequent-Value Encoded Word Store

This block is a word-addressed data array that saves storage power by recognising a small set of 32-bit values that occur often. A table of 32 such values is loaded through a programming port. Each table entry has a valid bit. When a word is written and it equals a valid table entry, only a 5-bit code and a flag are stored. The 27-bit upper field of that word is left untouched and may be treated as powered down. A word that matches no valid entry is stored whole across the upper and lower fields.

A read returns the full 32-bit value one clock after the request, whatever the word's encoding. For encoded words the code is expanded through the table. For raw words the two fields are joined. Both paths take the same single registered cycle.

Reprogramming any table entry discards the contents of every stored word, so that no word is ever decoded through a changed table. A counter output reports how many stored words currently have their upper field gated. Software or a testbench can use it to gauge the saving.

Top module: `fv_word_store`

## Requirements
- R1: A table write (`tbl_we`) stores `tbl_data` and the valid bit `tbl_vld_in` at entry `tbl_idx`. An entry whose valid bit is 0 never matches a written word, so such a word is stored raw.
- R2: A word write whose data equals a valid table entry is stored encoded (flag 0). A later read returns exactly the written 32-bit value.
- R3: A word write whose data matches no valid table entry is stored raw (flag 1). A later read returns exactly the written 32-bit value.
- R4: A read request (`rd_en`) puts the result on `rd_data` with `rd_valid` high on the next clock, for both encoded and raw words. `rd_valid` is low in a cycle that follows no request.
- R5: A read of a word that has not been written since reset, or since the last table write, returns zero.
- R6: A table write invalidates every stored word and sets `gated_cnt` to zero on the next clock. A word write in the same cycle as a table write is discarded.
- R7: `gated_cnt` equals the number of valid words stored encoded. It is updated on the clock edge that takes a word write, and overwriting a word replaces that word's old contribution.
- R8: When a read and a write target the same address in the same cycle, the read returns the content held before that write.
- R9: After reset, all table entries are invalid, no word is valid, `gated_cnt` is 0 and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 5 | Table entry index |
| tbl_data | input | 32 | Value for the table entry |
| tbl_vld_in | input | 1 | Valid bit for the table entry |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | AW (6) | Word write address |
| wr_data | input | 32 | Word write data |
| rd_en | input | 1 | Word read request |
| rd_addr | input | AW (6) | Word read address |
| rd_data | output | 32 | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result strobe, one clock after rd_en |
| gated_cnt | output | CW (7) | Count of valid words stored encoded |

## Verification
Two sets of events can share a cycle. A read can coincide with a word write to the same address. A table write can coincide with a word write or a read. The random phase confines addresses to a few locations and enables read, write and table writes independently, so these collisions occur often. The directed phase forces each collision once. A bench model holds the full value and validity of every word. A read is judged against the model state from before the clock edge. A discarded write and the flush to zero are judged through later reads and through `gated_cnt`.

// File: rtl/fv_word_store.sv
module fv_word_store #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 32,
  parameter int LOW_W  = 5,
  localparam int NFV    = 1 << LOW_W,
  localparam int HIGH_W = WORD_W - LOW_W,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [LOW_W-1:0]  tbl_idx,
  input  logic [WORD_W-1:0] tbl_data,
  input  logic              tbl_vld_in,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [CW-1:0]     gated_cnt
);

  logic [WORD_W-1:0] fv_val [NFV];
  logic [NFV-1:0]    fv_ok;

  logic [LOW_W-1:0]  lo_f  [DEPTH];
  logic [HIGH_W-1:0] hi_f  [DEPTH];
  logic [DEPTH-1:0]  raw_f;
  logic [DEPTH-1:0]  live;

  logic             hit;
  logic [LOW_W-1:0] code;
  logic             store_wr;
  logic             old_gated;

  always_comb begin
    hit  = 1'b0;
    code = '0;
    for (int i = NFV - 1; i >= 0; i--) begin
      if (fv_ok[i] && fv_val[i] == wr_data) begin
        hit  = 1'b1;
        code = LOW_W'(i);
      end
    end
  end

  assign store_wr  = wr_en && !tbl_we;
  assign old_gated = live[wr_addr] && !raw_f[wr_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_ok <= '0;
      for (int i = 0; i < NFV; i++) fv_val[i] <= '0;
    end else if (tbl_we) begin
      fv_ok[tbl_idx]  <= tbl_vld_in;
      fv_val[tbl_idx] <= tbl_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         live <= '0;
    else if (tbl_we)    live <= '0;
    else if (wr_en)     live[wr_addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (store_wr) begin
      raw_f[wr_addr] <= !hit;
      lo_f[wr_addr]  <= hit ? code : wr_data[LOW_W-1:0];
      if (!hit) hi_f[wr_addr] <= wr_data[WORD_W-1:LOW_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gated_cnt <= '0;
    else if (tbl_we)   gated_cnt <= '0;
    else if (wr_en)    gated_cnt <= gated_cnt - CW'(old_gated) + CW'(hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (!live[rd_addr])      rd_data <= '0;
        else if (raw_f[rd_addr]) rd_data <= {hi_f[rd_addr], lo_f[rd_addr]};
        else                     rd_data <= fv_val[lo_f[rd_addr]];
      end
    end
  end

endmodule

module fv_word_store_chk #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 32,
  parameter int CW     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tbl_we,
  input logic              wr_en,
  input logic              rd_en,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [CW-1:0]     gated_cnt
);

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid);                       // R4
  AST_RD_IDLE:      assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_valid);                     // R4
  AST_TBL_FLUSH:    assert property (@(posedge clk) disable iff (!rst_n) tbl_we |=> gated_cnt == '0);               // R6
  AST_STALE_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) ($past(tbl_we) && rd_en) |=> rd_data == '0); // R6
  AST_CNT_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) (!tbl_we && !wr_en) |=> $stable(gated_cnt)); // R7
  AST_CNT_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) gated_cnt <= CW'(DEPTH));                  // R7

endmodule

bind fv_word_store fv_word_store_chk #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .rd_valid(rd_valid), .gated_cnt(gated_cnt)
);

// File: tb/fv_word_store_tb.sv
`timescale 1ns/1ps
module fv_word_store_tb;
  localparam int DEPTH = 64;
  localparam int AW = 6;
  localparam int CW = 7;

  logic clk = 0;
  logic rst_n = 0;
  logic tbl_we = 0;
  logic [4:0] tbl_idx = 0;
  logic [31:0] tbl_data = 0;
  logic tbl_vld_in = 0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic rd_en = 0;
  logic [AW-1:0] rd_addr = 0;
  logic [31:0] rd_data;
  logic rd_valid;
  logic [CW-1:0] gated_cnt;

  always #2 clk = ~clk;

  fv_word_store u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
    .tbl_vld_in(tbl_vld_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .gated_cnt(gated_cnt)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] m_tval [32];
  bit          m_tok  [32];
  logic [31:0] m_val  [DEPTH];
  bit          m_live [DEPTH];

  function automatic bit is_fv(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (m_tok[i] && m_tval[i] == v) return 1;
    return 0;
  endfunction

  function automatic int exp_cnt();
    int c = 0;
    for (int i = 0; i < DEPTH; i++) if (m_live[i] && is_fv(m_val[i])) c++;
    return c;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit tw, logic [4:0] ti, logic [31:0] td, bit tv,
                      bit we, logic [AW-1:0] wa, logic [31:0] wd,
                      bit re, logic [AW-1:0] ra);
    logic [31:0] exp_rd;
    string rtag;
    tbl_we = tw; tbl_idx = ti; tbl_data = td; tbl_vld_in = tv;
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    exp_rd = m_live[ra] ? m_val[ra] : 32'h0;
    if (we && !tw && wa == ra) rtag = "R8";
    else if (!m_live[ra]) rtag = "R5";
    else if (is_fv(m_val[ra])) rtag = "R2";
    else rtag = "R3";
    @(posedge clk);
    #0.5;
    if (tw) begin
      m_tval[ti] = td; m_tok[ti] = tv;
      for (int i = 0; i < DEPTH; i++) m_live[i] = 0;
    end else if (we) begin
      m_val[wa] = wd; m_live[wa] = 1;
    end
    @(negedge clk);
    check("R4 rd_valid", 32'(rd_valid), 32'(re));
    if (re) check(rtag, rd_data, exp_rd);
    check(tw ? "R6 count" : "R7 count", 32'(gated_cnt), 32'(exp_cnt()));
    tbl_we = 0; wr_en = 0; rd_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) begin m_tval[i] = 0; m_tok[i] = 0; end
    for (int i = 0; i < DEPTH; i++) begin m_val[i] = 0; m_live[i] = 0; end
    repeat (3) @(negedge clk);
    check("R9 count", 32'(gated_cnt), 0);
    check("R9 rd_valid", 32'(rd_valid), 0);
    rst_n = 1;
    @(negedge clk);
    // R9/R5: unwritten reads zero; zero is not frequent with an empty table
    step(0, 0, 0, 0, 0, 0, 0, 1, 5);
    step(0, 0, 0, 0, 1, 5, 32'h0, 0, 0);
    check("R9 empty table", 32'(gated_cnt), 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 5);
    // R1: invalid entry never matches
    step(1, 5'd3, 32'h0000_1234, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 7, 32'h0000_1234, 0, 0);
    check("R1 invalid entry", 32'(gated_cnt), 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 7);
    // load table, R2 encoded, R3 raw
    step(1, 5'd0, 32'h0000_0000, 1, 0, 0, 0, 0, 0);
    step(1, 5'd1, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, 0);
    step(1, 5'd31, 32'h0010_0000, 1, 0, 0, 0, 0, 0);
    step(1, 5'd9, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 2, 32'hFFFF_FFFF, 0, 0);
    step(0, 0, 0, 0, 1, 3, 32'h0010_0000, 0, 0);
    step(0, 0, 0, 0, 1, 4, 32'hDEAD_BEEF, 0, 0);
    check("R7 two gated", 32'(gated_cnt), 2);
    step(0, 0, 0, 0, 0, 0, 0, 1, 2);
    step(0, 0, 0, 0, 0, 0, 0, 1, 3);
    step(0, 0, 0, 0, 0, 0, 0, 1, 4);
    // R7 overwrite encoded with raw and back
    step(0, 0, 0, 0, 1, 2, 32'h1234_5678, 0, 0);
    step(0, 0, 0, 0, 1, 4, 32'h0000_0000, 0, 0);
    // R8 read and write same address
    step(0, 0, 0, 0, 1, 3, 32'hCAFE_0001, 1, 3);
    step(0, 0, 0, 0, 0, 0, 0, 1, 3);
    // R6 table write with concurrent word write and read
    step(1, 5'd4, 32'h0000_00FF, 1, 1, 6, 32'h0000_00FF, 1, 4);
    step(0, 0, 0, 0, 0, 0, 0, 1, 6);
    step(0, 0, 0, 0, 0, 0, 0, 1, 4);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      bit tw, tv, we, re;
      logic [4:0] ti;
      logic [31:0] td, wd;
      tw = ($urandom % 40) == 0;
      ti = 5'($urandom);
      tv = ($urandom % 4) != 0;
      td = ($urandom % 2) ? 32'($urandom % 8) : $urandom;
      we = ($urandom % 2) == 1;
      re = ($urandom % 2) == 1;
      if ($urandom % 2) wd = m_tval[$urandom % 32];
      else if ($urandom % 2) wd = 32'($urandom % 8);
      else wd = $urandom;
      step(tw, ti, td, tv, we, AW'($urandom % 8), wd, re, AW'($urandom % 8));
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule